// File: doc/BRIEF.md
# Three-Channel Pulse Coincidence Filter

This block sits behind three pulse-capture channels. Each channel hands over a finished pulse record that carries the time at which the pulse first crossed its threshold, counted on a free-running high-speed counter. The filter holds each record until the counter has moved far enough past that time that no partner could still arrive. It then decides whether any other channel saw a pulse whose first-crossing time lies within a programmable distance of its own. Paired pulses leave on a coincidence stream, tagged with their port code and a sequence number that counts per port. Unpaired pulses are not forwarded; they only add to a per-channel rejection count. After a programmable number of rejected pulses, a tally snapshot is emitted and the counts restart.

Each input channel is a valid/ready stream with a one-record holding slot, so `in_ready` for a channel is low from the cycle after a record is taken until that record has been resolved. Both output streams are registered. A record stays on an output with a stable payload until the consumer raises ready. If the register that a resolution needs is still full and is not being drained, that resolution waits, and its channel keeps `in_ready` low. Pairing is judged between any two channels. Requiring all three channels to fire together is left to downstream logic. A record must be presented no more than `SLACK` counter ticks after its own first-crossing time, and the time counter must advance once per clock.

Top module: `coin_filter`

## Requirements
- R1: Each channel holds at most one record. `in_ready[k]` is high exactly when channel k holds none, and it goes low in the cycle after a record is accepted.
- R2: A held record is coincident when the most recent record of another channel has a first-crossing time whose modular distance from its own is at most `win_cycles`. The two records may be accepted in any order or in the same cycle.
- R3: A record is resolved in the first cycle where `now_time - stamp > win_cycles + SLACK` and its destination is free. When nothing else is waiting, the resulting output becomes valid with `now_time == stamp + win_cycles + SLACK + 2`.
- R4: A coincident record is emitted with `co_port` = 1, 2 or 3 for input channel 0, 1 or 2, and with its own first-crossing time on `co_stamp`.
- R5: `co_seq` counts coincident records on that port only. It is 0 for the first one after reset, rises by 1 for each later one, and wraps at 2^SEQW.
- R6: A record without a partner never appears on the coincidence stream. It adds 1 to the rejection count of its channel.
- R7: When the number of rejections since the last snapshot reaches `tally_limit` (0 behaves as 1), a snapshot is emitted and the counts clear. In the snapshot, `tl_count[k*CNTW +: CNTW]` is the count of channel k including this rejection, and `tl_stamp` is this rejected record's first-crossing time.
- R8: At most one record is resolved per cycle. When several are due together, the lowest channel index goes first.
- R9: Both output streams keep valid and payload stable while ready is low. A resolution whose destination register is full waits, and its channel keeps `in_ready` low.
- R10: After reset both output streams are invalid, all `in_ready` bits are high, and all sequence numbers and counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| now_time | input | TW | Free-running high-speed counter value |
| win_cycles | input | TW | Coincidence half-window in counter ticks |
| tally_limit | input | CNTW | Rejections per snapshot (0 behaves as 1) |
| in_valid | input | 3 | Per-channel record valid |
| in_ready | output | 3 | Per-channel record ready |
| in_stamp | input | 3*TW | First-crossing times, channel k at [k*TW +: TW] |
| co_valid | output | 1 | Coincident record valid |
| co_ready | input | 1 | Coincident record ready |
| co_port | output | 2 | Port code 1..3 |
| co_seq | output | SEQW | Per-port sequence number |
| co_stamp | output | TW | First-crossing time of the record |
| tl_valid | output | 1 | Tally snapshot valid |
| tl_ready | input | 1 | Tally snapshot ready |
| tl_count | output | 3*CNTW | Per-channel rejection counts |
| tl_stamp | output | TW | First-crossing time of the last tallied record |

## Verification
On every cycle, the assertions check that output payloads hold still under back-pressure and that a channel drops its ready after an accept. They also check that every port code is legal, that every snapshot counts at least one rejection, and that no coincident record appears before its age exceeds the window plus slack. Whether a pair is judged correctly at each distance around the window edge, the per-port sequence numbering and its wrap, the exact cycle of release, the port ordering of simultaneous records, and the contents of snapshots can only be shown by the bench's sweep of channel pairs and offsets against its arithmetic model.

// File: rtl/coin_filter_pkg.sv
package coin_filter_pkg;
  localparam int NCH   = 3;
  localparam int PORTW = $clog2(NCH + 1);
endpackage

// File: rtl/coin_filter_slot.sv
module coin_filter_slot #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          drop,
  input  logic          hit,
  input  logic [TW-1:0] stamp_in,
  output logic          pend,
  output logic          seen,
  output logic          matched,
  output logic [TW-1:0] stamp
);
  // One held record per channel; the stamp stays as "most recent" after release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      seen    <= 1'b0;
      matched <= 1'b0;
      stamp   <= '0;
    end else if (take) begin
      pend    <= 1'b1;
      seen    <= 1'b1;
      matched <= hit;
      stamp   <= stamp_in;
    end else if (drop) begin
      pend    <= 1'b0;
      matched <= 1'b0;
    end else if (pend && hit) begin
      matched <= 1'b1;
    end
  end
endmodule

// File: rtl/coin_filter_match.sv
module coin_filter_match
  import coin_filter_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic [NCH*TW-1:0] eff_stamp,
  input  logic [NCH-1:0]    eff_seen,
  input  logic [TW-1:0]     win,
  output logic [NCH-1:0]    hit
);
  for (genvar i = 0; i < NCH; i++) begin : g_row
    logic [NCH-1:0] row;
    for (genvar j = 0; j < NCH; j++) begin : g_col
      if (i != j) begin : g_pair
        logic [TW-1:0] diff;
        logic [TW-1:0] mag;
        assign diff   = eff_stamp[i*TW +: TW] - eff_stamp[j*TW +: TW];
        assign mag    = diff[TW-1] ? -diff : diff;
        assign row[j] = eff_seen[i] & eff_seen[j] & (mag <= win);
      end else begin : g_self
        assign row[j] = 1'b0;
      end
    end
    assign hit[i] = |row;
  end
endmodule

// File: rtl/coin_filter_tally.sv
module coin_filter_tally
  import coin_filter_pkg::*;
#(
  parameter int TW   = 16,
  parameter int CNTW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bump,
  input  logic [PORTW-1:0]  bump_ch,
  input  logic [TW-1:0]     bump_stamp,
  input  logic [CNTW-1:0]   limit,
  input  logic              tl_ready,
  output logic              tl_valid,
  output logic [NCH*CNTW-1:0] tl_count,
  output logic [TW-1:0]     tl_stamp,
  output logic              free
);
  logic [CNTW-1:0]     cnt_q [NCH];
  logic [CNTW-1:0]     total_q;
  logic [CNTW:0]       total_nx;
  logic [NCH*CNTW-1:0] cnt_nx;
  logic                fire;

  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      cnt_nx[k*CNTW +: CNTW] = cnt_q[k] + CNTW'(bump_ch == PORTW'(k));
    end
  end

  assign total_nx = (CNTW+1)'(total_q) + (CNTW+1)'(1);
  assign fire     = bump && (total_nx >= (CNTW+1)'(limit));
  assign free     = !tl_valid || tl_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tl_valid <= 1'b0;
      tl_count <= '0;
      tl_stamp <= '0;
      total_q  <= '0;
      for (int k = 0; k < NCH; k++) cnt_q[k] <= '0;
    end else if (fire) begin
      tl_valid <= 1'b1;
      tl_count <= cnt_nx;
      tl_stamp <= bump_stamp;
      total_q  <= '0;
      for (int k = 0; k < NCH; k++) cnt_q[k] <= '0;
    end else begin
      if (bump) begin
        total_q <= total_nx[CNTW-1:0];
        for (int k = 0; k < NCH; k++) cnt_q[k] <= cnt_nx[k*CNTW +: CNTW];
      end
      if (tl_ready) tl_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/coin_filter.sv
module coin_filter
  import coin_filter_pkg::*;
#(
  parameter int TW    = 16,
  parameter int SEQW  = 8,
  parameter int CNTW  = 8,
  parameter int SLACK = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TW-1:0]       now_time,
  input  logic [TW-1:0]       win_cycles,
  input  logic [CNTW-1:0]     tally_limit,
  input  logic [2:0]          in_valid,
  output logic [2:0]          in_ready,
  input  logic [3*TW-1:0]     in_stamp,
  output logic                co_valid,
  input  logic                co_ready,
  output logic [1:0]          co_port,
  output logic [SEQW-1:0]     co_seq,
  output logic [TW-1:0]       co_stamp,
  output logic                tl_valid,
  input  logic                tl_ready,
  output logic [3*CNTW-1:0]   tl_count,
  output logic [TW-1:0]       tl_stamp
);
  localparam logic [TW:0] SLACK_W = (TW+1)'(SLACK);

  logic [NCH-1:0]    pend, seen, matched, take, drop, hit, due;
  logic [NCH*TW-1:0] stamp_flat, eff_stamp;
  logic [PORTW-1:0]  sel;
  logic              any_due, coin_now, co_free, tl_free, go, bump;
  logic [TW-1:0]     sel_stamp;
  logic [SEQW-1:0]   seq_q [NCH];

  assign in_ready = ~pend;
  assign take     = in_valid & ~pend;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [TW-1:0] age;
    coin_filter_slot #(.TW(TW)) slot_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take[k]),
      .drop     (drop[k]),
      .hit      (hit[k]),
      .stamp_in (in_stamp[k*TW +: TW]),
      .pend     (pend[k]),
      .seen     (seen[k]),
      .matched  (matched[k]),
      .stamp    (stamp_flat[k*TW +: TW])
    );
    assign eff_stamp[k*TW +: TW] = take[k] ? in_stamp[k*TW +: TW] : stamp_flat[k*TW +: TW];
    assign age    = now_time - stamp_flat[k*TW +: TW];
    assign due[k] = pend[k] && ({1'b0, age} > ({1'b0, win_cycles} + SLACK_W));
  end

  coin_filter_match #(.TW(TW)) match_i (
    .eff_stamp (eff_stamp),
    .eff_seen  (take | seen),
    .win       (win_cycles),
    .hit       (hit)
  );

  // Fixed priority: the lowest due channel is resolved first.
  always_comb begin
    sel     = '0;
    any_due = 1'b0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (due[k]) begin
        sel     = PORTW'(k);
        any_due = 1'b1;
      end
    end
  end

  assign sel_stamp = stamp_flat[int'(sel)*TW +: TW];
  assign coin_now  = matched[sel] | hit[sel];
  assign co_free   = !co_valid || co_ready;
  assign go        = any_due && (coin_now ? co_free : tl_free);
  assign drop      = go ? (NCH'(1) << sel) : '0;
  assign bump      = go && !coin_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      co_valid <= 1'b0;
      co_port  <= '0;
      co_seq   <= '0;
      co_stamp <= '0;
      for (int k = 0; k < NCH; k++) seq_q[k] <= '0;
    end else if (go && coin_now) begin
      co_valid   <= 1'b1;
      co_port    <= sel + PORTW'(1);
      co_seq     <= seq_q[sel];
      co_stamp   <= sel_stamp;
      seq_q[sel] <= seq_q[sel] + SEQW'(1);
    end else if (co_ready) begin
      co_valid <= 1'b0;
    end
  end

  coin_filter_tally #(.TW(TW), .CNTW(CNTW)) tally_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bump       (bump),
    .bump_ch    (sel),
    .bump_stamp (sel_stamp),
    .limit      (tally_limit),
    .tl_ready   (tl_ready),
    .tl_valid   (tl_valid),
    .tl_count   (tl_count),
    .tl_stamp   (tl_stamp),
    .free       (tl_free)
  );
endmodule

// File: rtl/coin_filter_chk.sv
module coin_filter_chk #(
  parameter int TW    = 16,
  parameter int SEQW  = 8,
  parameter int CNTW  = 8,
  parameter int SLACK = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TW-1:0]     now_time,
  input logic [TW-1:0]     win_cycles,
  input logic [2:0]        in_valid,
  input logic [2:0]        in_ready,
  input logic              co_valid,
  input logic              co_ready,
  input logic [1:0]        co_port,
  input logic [SEQW-1:0]   co_seq,
  input logic [TW-1:0]     co_stamp,
  input logic              tl_valid,
  input logic              tl_ready,
  input logic [3*CNTW-1:0] tl_count,
  input logic [TW-1:0]     tl_stamp
);
  logic [CNTW+1:0] tally_sum;
  logic [TW-1:0]   co_age;

  always_comb begin
    tally_sum = '0;
    for (int k = 0; k < 3; k++) tally_sum += (CNTW+2)'(tl_count[k*CNTW +: CNTW]);
  end
  assign co_age = now_time - co_stamp;

  assert_in_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|(in_valid & in_ready)) |=> ((in_ready & $past(in_valid & in_ready)) == 3'b000));

  assert_release_age_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(co_valid) && $stable(win_cycles)) |->
      ({1'b0, co_age} > ({1'b0, win_cycles} + (TW+1)'(SLACK))));

  assert_port_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    co_valid |-> (co_port >= 2'd1 && co_port <= 2'd3));

  assert_tally_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tl_valid |-> (tally_sum != '0));

  assert_co_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (co_valid && !co_ready) |=> (co_valid && $stable(co_port) && $stable(co_seq) && $stable(co_stamp)));

  assert_tl_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tl_valid && !tl_ready) |=> (tl_valid && $stable(tl_count) && $stable(tl_stamp)));
endmodule

bind coin_filter coin_filter_chk #(.TW(TW), .SEQW(SEQW), .CNTW(CNTW), .SLACK(SLACK)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .now_time   (now_time),
  .win_cycles (win_cycles),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .co_valid   (co_valid),
  .co_ready   (co_ready),
  .co_port    (co_port),
  .co_seq     (co_seq),
  .co_stamp   (co_stamp),
  .tl_valid   (tl_valid),
  .tl_ready   (tl_ready),
  .tl_count   (tl_count),
  .tl_stamp   (tl_stamp)
);

// File: tb/coin_filter_tb_top.sv
module coin_filter_tb_top;
  localparam int TW = 16, SEQW = 3, CNTW = 8, SLACK = 4, WIN = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [TW-1:0]     now_time = '0;
  logic [TW-1:0]     win_cycles = TW'(WIN);
  logic [CNTW-1:0]   tally_limit = CNTW'(3);
  logic [2:0]        in_valid = '0;
  logic [2:0]        in_ready;
  logic [3*TW-1:0]   in_stamp = '0;
  logic              co_valid, co_ready = 1'b1;
  logic [1:0]        co_port;
  logic [SEQW-1:0]   co_seq;
  logic [TW-1:0]     co_stamp;
  logic              tl_valid, tl_ready = 1'b1;
  logic [3*CNTW-1:0] tl_count;
  logic [TW-1:0]     tl_stamp;

  always #10 clk = ~clk;
  always @(posedge clk) now_time <= now_time + TW'(1);

  coin_filter #(.TW(TW), .SEQW(SEQW), .CNTW(CNTW), .SLACK(SLACK)) dut_i (
    .clk(clk), .rst_n(rst_n), .now_time(now_time), .win_cycles(win_cycles),
    .tally_limit(tally_limit), .in_valid(in_valid), .in_ready(in_ready),
    .in_stamp(in_stamp), .co_valid(co_valid), .co_ready(co_ready),
    .co_port(co_port), .co_seq(co_seq), .co_stamp(co_stamp),
    .tl_valid(tl_valid), .tl_ready(tl_ready), .tl_count(tl_count), .tl_stamp(tl_stamp)
  );

  int checks = 0, errors = 0, cyc = 0;
  int co_n = 0, tl_n = 0;
  int cap_co_port [512], cap_co_seq [512], cap_co_stamp [512], cap_co_time [512];
  int cap_tl_c [512][3], cap_tl_stamp [512], cap_tl_time [512];

  always @(negedge clk) begin
    if (co_valid && co_ready && co_n < 512) begin
      cap_co_port[co_n] = int'(co_port);   cap_co_seq[co_n]  = int'(co_seq);
      cap_co_stamp[co_n] = int'(co_stamp); cap_co_time[co_n] = int'(now_time);
      co_n++;
    end
    if (tl_valid && tl_ready && tl_n < 512) begin
      for (int k = 0; k < 3; k++) cap_tl_c[tl_n][k] = int'(tl_count[k*CNTW +: CNTW]);
      cap_tl_stamp[tl_n] = int'(tl_stamp); cap_tl_time[tl_n] = int'(now_time);
      tl_n++;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 50000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Bench model state and the current episode.
  int exp_seq [3], exp_cnt [3], exp_total = 0;
  int ep_n = 0, ep_port [4], ep_off [4], ep_stamp [4];
  int co_base = 0, tl_base = 0;

  task automatic add_pulse(input int p, input int off);
    ep_port[ep_n] = p; ep_off[ep_n] = off; ep_n++;
  endtask

  task automatic inject();
    int maxoff = 0;
    co_base = co_n; tl_base = tl_n;
    for (int i = 0; i < ep_n; i++) if (ep_off[i] > maxoff) maxoff = ep_off[i];
    for (int off = 0; off <= maxoff; off++) begin
      @(negedge clk);
      in_valid = '0;
      for (int i = 0; i < ep_n; i++) if (ep_off[i] == off) begin
        in_valid[ep_port[i]] = 1'b1;
        in_stamp[ep_port[i]*TW +: TW] = now_time;
        ep_stamp[i] = int'(now_time);
      end
    end
    @(negedge clk);
    in_valid = '0;
    for (int i = 0; i < ep_n; i++) if (ep_off[i] == maxoff)
      check(in_ready[ep_port[i]] == 1'b0, "R1", "in_ready after accept", int'(in_ready[ep_port[i]]), 0);
    repeat (WIN + SLACK + 10) @(negedge clk);
  endtask

  task automatic verify(input bit use_time);
    int ord [4];
    int ci = co_base, ti = tl_base, rel_prev = -1000, lim;
    lim = (tally_limit == 0) ? 1 : int'(tally_limit);
    for (int i = 0; i < ep_n; i++) ord[i] = i;
    for (int a = 0; a < ep_n; a++)
      for (int b = 0; b + 1 < ep_n - a; b++)
        if (ep_stamp[ord[b]] > ep_stamp[ord[b+1]] ||
            (ep_stamp[ord[b]] == ep_stamp[ord[b+1]] && ep_port[ord[b]] > ep_port[ord[b+1]])) begin
          int t = ord[b]; ord[b] = ord[b+1]; ord[b+1] = t;
        end
    for (int r = 0; r < ep_n; r++) begin
      int i = ord[r], p = ep_port[ord[r]], rel;
      bit coin = 0;
      for (int j = 0; j < ep_n; j++) begin
        int d = ep_stamp[i] - ep_stamp[j];
        if (d < 0) d = -d;
        if (ep_port[j] != p && d <= WIN) coin = 1;
      end
      rel = ep_stamp[i] + WIN + SLACK + 2;
      if (rel <= rel_prev) rel = rel_prev + 1;
      rel_prev = rel;
      if (coin) begin
        check(ci < co_n, "R2", "coincident record present", co_n, ci + 1);
        check(cap_co_port[ci] == p + 1, "R4", "port code", cap_co_port[ci], p + 1);
        check(cap_co_stamp[ci] == ep_stamp[i], "R4", "stamp", cap_co_stamp[ci], ep_stamp[i]);
        check(cap_co_seq[ci] == exp_seq[p] % (1 << SEQW), "R5", "sequence", cap_co_seq[ci], exp_seq[p] % (1 << SEQW));
        if (use_time) check(cap_co_time[ci] == rel, "R3", "release cycle", cap_co_time[ci], rel);
        exp_seq[p]++; ci++;
      end else begin
        exp_cnt[p]++; exp_total++;
        if (exp_total >= lim) begin
          check(ti < tl_n, "R7", "snapshot present", tl_n, ti + 1);
          for (int k = 0; k < 3; k++)
            check(cap_tl_c[ti][k] == exp_cnt[k], "R7", "channel count", cap_tl_c[ti][k], exp_cnt[k]);
          check(cap_tl_stamp[ti] == ep_stamp[i], "R7", "snapshot stamp", cap_tl_stamp[ti], ep_stamp[i]);
          if (use_time) check(cap_tl_time[ti] == rel, "R3", "snapshot cycle", cap_tl_time[ti], rel);
          for (int k = 0; k < 3; k++) exp_cnt[k] = 0;
          exp_total = 0; ti++;
        end
      end
    end
    check(co_n == ci, "R6", "coincident record total", co_n, ci);
    check(tl_n == ti, "R7", "snapshot total", tl_n, ti);
    ep_n = 0;
  endtask

  initial begin
    for (int k = 0; k < 3; k++) begin exp_seq[k] = 0; exp_cnt[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(co_valid == 1'b0, "R10", "co_valid after reset", int'(co_valid), 0);
    check(tl_valid == 1'b0, "R10", "tl_valid after reset", int'(tl_valid), 0);
    check(in_ready == 3'b111, "R10", "in_ready after reset", int'(in_ready), 7);

    // Lone pulses on each channel: rejected, snapshot after the third (R6, R7).
    for (int p = 0; p < 3; p++) begin add_pulse(p, 0); inject(); verify(1); end

    // Sweep of every ordered pair and offset around the window edge (R2, R3, R5).
    tally_limit = CNTW'(4);
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        if (a != b)
          for (int d = 0; d <= WIN + 2; d++) begin
            add_pulse(a, 0); add_pulse(b, d); inject(); verify(1);
          end

    // Three records due in one cycle leave in port order, one per cycle (R8).
    add_pulse(2, 0); add_pulse(0, 0); add_pulse(1, 0);
    inject();
    for (int k = 0; k < 3; k++) begin
      check(cap_co_port[co_base + k] == k + 1, "R8", "port order", cap_co_port[co_base + k], k + 1);
      check(cap_co_time[co_base + k] == cap_co_time[co_base] + k, "R8", "one per cycle",
            cap_co_time[co_base + k], cap_co_time[co_base] + k);
    end
    verify(1);

    // Chain: only the closer pair is coincident (R2, R6).
    add_pulse(0, 0); add_pulse(1, WIN + 1); add_pulse(2, 2 * WIN + 1);
    inject(); verify(1);

    // Limit zero behaves as one (R7).
    tally_limit = '0;
    add_pulse(2, 0); inject(); verify(1);
    tally_limit = CNTW'(2);

    // Back-pressure on the coincidence stream (R9, R1).
    @(posedge clk); #1 co_ready = 1'b0;
    add_pulse(0, 0); add_pulse(1, 0);
    inject();
    check(co_valid == 1'b1, "R9", "co_valid held", int'(co_valid), 1);
    check(co_port == 2'd1, "R9", "held port", int'(co_port), 1);
    check(in_ready[1] == 1'b0, "R9", "stalled channel ready", int'(in_ready[1]), 0);
    check(in_ready[0] == 1'b1, "R1", "released channel ready", int'(in_ready[0]), 1);
    @(posedge clk); #1 co_ready = 1'b1;
    repeat (6) @(negedge clk);
    verify(0);
    check(in_ready == 3'b111, "R1", "all channels free", int'(in_ready), 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule